// File: doc/BRIEF.md
# Burst-Mode Send Handshake Controller

This block is a clocked controller that sits between a requesting processing element and a transmit path. It has eleven states and steps through a fixed set of burst-mode arcs. Each arc fires when its input condition holds. When it fires, the block moves to the arc's target state and sets or clears only the outputs that arc names. Every other output keeps its value.

All five handshake inputs arrive asynchronously. Each one passes through a two-flop synchronizer, and the arc conditions are evaluated as levels on the synchronized values. A change at an input therefore reaches the outputs on the third rising clock edge after it settles. At most one arc fires per clock.

The inputs `rd_iq_i` and `ack_pkt_i` must never be high together. If they are seen high together, the block raises a sticky protocol error and freezes its state and outputs until reset.

Top module: `bm_send_ctrl`

## Requirements
- R1: While `rst_ni` is low and after its release, the block is in state 0 with `tack_o`, `peack_o`, `adbld_o` and `protocol_error_o` all low.
- R2: A change at the inputs that fires an arc becomes visible at the outputs on the third rising edge of `clk_i` after the change, and not on the second.
- R3: State 0 goes to state 1 and sets adbld when req_send, treq and rd_iq are high. State 1 goes to state 2 and sets peack when adbld_out is high. State 2 goes to state 3 when rd_iq is low; that arc clears peack and adbld and sets tack.
- R4: In state 3, with treq and adbld_out both low, rd_iq high leads to state 4 and sets adbld, and ack_pkt high leads to state 8 and sets peack.
- R5: State 4 goes to state 5 and sets peack when adbld_out is high. State 5 goes to state 6 when rd_iq is low and clears peack, adbld and tack.
- R6: In state 6, with treq high and adbld_out low, rd_iq high returns to state 1 and sets adbld, and ack_pkt high leads to state 7 and sets peack and tack.
- R7: State 7 goes to state 9 when ack_pkt and treq are both low, and state 8 goes to state 9 when ack_pkt is low. Both arcs clear peack and tack.
- R8: State 9 goes to state 10 and sets tack when treq is high. State 10 returns to state 9 and clears tack when treq is low. State 9 returns to state 0 with no output change when req_send is low. If treq is high and req_send is low at the same time in state 9, the arc to state 10 wins.
- R9: Inputs that do not complete the current state's arc condition have no effect. An output changes only on an arc that names it.
- R10: If synchronized rd_iq and ack_pkt are high together, `protocol_error_o` rises three edges after the inputs do and stays high until reset. While it is high, the state and the three handshake outputs are frozen.
- R11: Every state change follows one of the arcs listed in R3 to R8, and at most one arc fires per clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| req_send_i | input | 1 | Send request from the processing element |
| treq_i | input | 1 | Transmit request |
| rd_iq_i | input | 1 | Input-queue read indication |
| adbld_out_i | input | 1 | Address build acknowledge |
| ack_pkt_i | input | 1 | Packet acknowledge |
| tack_o | output | 1 | Transmit acknowledge |
| peack_o | output | 1 | Processing-element acknowledge |
| adbld_o | output | 1 | Address build request |
| protocol_error_o | output | 1 | Sticky flag for simultaneous rd_iq and ack_pkt |

## Verification
The assertions assume the environment keeps to burst-mode order. Inputs change only in bursts that the current state is waiting for, and rd_iq and ack_pkt stay mutually exclusive except in the one deliberate error case. The stimulus waits three edges after every burst before driving the next one, so each burst is fully absorbed and no two arcs chain by accident. Each burst is also chosen so that, in the state it lands in, it cannot satisfy the next arc's condition. The state-9 priority case and the error case are the only places where conflicting conditions are driven on purpose.

// File: rtl/bm_send_pkg.sv
package bm_send_pkg;

  typedef enum logic [3:0] {
    S0 = 4'd0, S1 = 4'd1, S2 = 4'd2, S3 = 4'd3, S4 = 4'd4, S5 = 4'd5,
    S6 = 4'd6, S7 = 4'd7, S8 = 4'd8, S9 = 4'd9, S10 = 4'd10
  } bm_state_e;

  typedef struct packed {
    logic req_send;
    logic treq;
    logic rd_iq;
    logic adbld_out;
    logic ack_pkt;
  } bm_in_t;

  typedef struct packed {
    logic tack;
    logic peack;
    logic adbld;
  } bm_out_t;

  localparam int unsigned IN_W  = $bits(bm_in_t);
  localparam int unsigned OUT_W = $bits(bm_out_t);

endpackage

// File: rtl/bm_sync.sv
module bm_sync #(
  parameter int unsigned WIDTH  = 1,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);

  logic [WIDTH-1:0] stage_q [STAGES];

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    if (g == 0) begin : g_first
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) stage_q[g] <= '0;
        else         stage_q[g] <= d_i;
      end
    end else begin : g_next
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) stage_q[g] <= '0;
        else         stage_q[g] <= stage_q[g-1];
      end
    end
  end

  assign q_o = stage_q[STAGES-1];

endmodule

// File: rtl/bm_arc_logic.sv
module bm_arc_logic
  import bm_send_pkg::*;
(
  input  bm_state_e state_i,
  input  bm_in_t    in_i,
  input  bm_out_t   out_i,
  output bm_state_e state_o,
  output bm_out_t   out_o
);

  always_comb begin
    state_o = state_i;
    out_o   = out_i;
    case (state_i)
      S0: if (in_i.req_send && in_i.treq && in_i.rd_iq) begin
        state_o = S1; out_o.adbld = 1'b1;
      end
      S1: if (in_i.adbld_out) begin
        state_o = S2; out_o.peack = 1'b1;
      end
      S2: if (!in_i.rd_iq) begin
        state_o = S3; out_o.peack = 1'b0; out_o.adbld = 1'b0; out_o.tack = 1'b1;
      end
      S3: if (!in_i.treq && !in_i.adbld_out) begin
        if (in_i.rd_iq) begin
          state_o = S4; out_o.adbld = 1'b1;
        end else if (in_i.ack_pkt) begin
          state_o = S8; out_o.peack = 1'b1;
        end
      end
      S4: if (in_i.adbld_out) begin
        state_o = S5; out_o.peack = 1'b1;
      end
      S5: if (!in_i.rd_iq) begin
        state_o = S6; out_o = '0;
      end
      S6: if (in_i.treq && !in_i.adbld_out) begin
        if (in_i.rd_iq) begin
          state_o = S1; out_o.adbld = 1'b1;
        end else if (in_i.ack_pkt) begin
          state_o = S7; out_o.peack = 1'b1; out_o.tack = 1'b1;
        end
      end
      S7: if (!in_i.ack_pkt && !in_i.treq) begin
        state_o = S9; out_o.peack = 1'b0; out_o.tack = 1'b0;
      end
      S8: if (!in_i.ack_pkt) begin
        state_o = S9; out_o.peack = 1'b0; out_o.tack = 1'b0;
      end
      S9: begin
        // treq arc has priority over the return to idle
        if (in_i.treq) begin
          state_o = S10; out_o.tack = 1'b1;
        end else if (!in_i.req_send) begin
          state_o = S0;
        end
      end
      S10: if (!in_i.treq) begin
        state_o = S9; out_o.tack = 1'b0;
      end
      default: begin
        state_o = S0; out_o = '0;
      end
    endcase
  end

endmodule

// File: rtl/bm_send_ctrl.sv
module bm_send_ctrl
  import bm_send_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic req_send_i,
  input  logic treq_i,
  input  logic rd_iq_i,
  input  logic adbld_out_i,
  input  logic ack_pkt_i,
  output logic tack_o,
  output logic peack_o,
  output logic adbld_o,
  output logic protocol_error_o
);

  bm_in_t    in_raw, in_s;
  bm_state_e state_q, state_d;
  bm_out_t   out_q, out_d;
  logic      err_q, mutex_hit;

  assign in_raw = '{req_send: req_send_i, treq: treq_i, rd_iq: rd_iq_i,
                    adbld_out: adbld_out_i, ack_pkt: ack_pkt_i};

  bm_sync #(.WIDTH(IN_W), .STAGES(SYNC_STAGES)) i_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (in_raw),
    .q_o   (in_s)
  );

  bm_arc_logic i_arc (
    .state_i(state_q),
    .in_i   (in_s),
    .out_i  (out_q),
    .state_o(state_d),
    .out_o  (out_d)
  );

  assign mutex_hit = in_s.rd_iq && in_s.ack_pkt;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= S0;
      out_q   <= '0;
      err_q   <= 1'b0;
    end else if (err_q || mutex_hit) begin
      err_q <= 1'b1;
    end else begin
      state_q <= state_d;
      out_q   <= out_d;
    end
  end

  assign tack_o           = out_q.tack;
  assign peack_o          = out_q.peack;
  assign adbld_o          = out_q.adbld;
  assign protocol_error_o = err_q;

endmodule

// File: rtl/bm_send_chk.sv
module bm_send_chk
  import bm_send_pkg::*;
(
  input logic      clk_i,
  input logic      rst_ni,
  input bm_state_e state_q,
  input logic      treq_s,
  input logic      rd_s,
  input logic      ack_s,
  input logic      tack_o,
  input logic      peack_o,
  input logic      adbld_o,
  input logic      protocol_error_o
);

  function automatic logic legal_step(bm_state_e a, bm_state_e b);
    case (a)
      S0:  return b == S1;
      S1:  return b == S2;
      S2:  return b == S3;
      S3:  return b == S4 || b == S8;
      S4:  return b == S5;
      S5:  return b == S6;
      S6:  return b == S1 || b == S7;
      S7:  return b == S9;
      S8:  return b == S9;
      S9:  return b == S10 || b == S0;
      S10: return b == S9;
      default: return 1'b0;
    endcase
  endfunction

  AST_LEGAL_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q != $past(state_q)) |-> legal_step($past(state_q), state_q)); // R11
  AST_ERR_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_s && ack_s) |=> protocol_error_o); // R10
  AST_ERR_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    protocol_error_o |=> protocol_error_o); // R10
  AST_ERR_FREEZE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    protocol_error_o |=> ($stable(state_q) && $stable({tack_o, peack_o, adbld_o}))); // R10
  AST_S9_PRIORITY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == S9 && treq_s && !(rd_s && ack_s) && !protocol_error_o) |=> state_q == S10); // R8
  AST_TACK_ARCS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(tack_o) |-> (state_q == S3 || state_q == S7 || state_q == S10)); // R9
  AST_PEACK_ARCS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(peack_o) |-> (state_q == S2 || state_q == S5 || state_q == S7 || state_q == S8)); // R9
  AST_ADBLD_ARCS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(adbld_o) |-> (state_q == S1 || state_q == S4)); // R9

endmodule

bind bm_send_ctrl bm_send_chk i_chk (
  .clk_i           (clk_i),
  .rst_ni          (rst_ni),
  .state_q         (state_q),
  .treq_s          (in_s.treq),
  .rd_s            (in_s.rd_iq),
  .ack_s           (in_s.ack_pkt),
  .tack_o          (tack_o),
  .peack_o         (peack_o),
  .adbld_o         (adbld_o),
  .protocol_error_o(protocol_error_o)
);

// File: tb/test_bm_send_ctrl.sv
`timescale 1ns/1ps
module test_bm_send_ctrl;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic req_send, treq, rd_iq, adbld_out, ack_pkt;
  logic tack, peack, adbld, perr;
  int   n_checks = 0;
  int   n_errors = 0;
  bit   done = 1'b0;

  always #4 clk = ~clk;

  bm_send_ctrl i_bm_send_ctrl (
    .clk_i(clk), .rst_ni(rst_ni),
    .req_send_i(req_send), .treq_i(treq), .rd_iq_i(rd_iq),
    .adbld_out_i(adbld_out), .ack_pkt_i(ack_pkt),
    .tack_o(tack), .peack_o(peack), .adbld_o(adbld), .protocol_error_o(perr)
  );

  // expected order: {tack, peack, adbld}
  task automatic chk_outs(string req, logic [2:0] exp);
    n_checks++;
    if ({tack, peack, adbld} !== exp) begin
      n_errors++;
      $display("FAIL %s outs act=%b exp=%b", req, {tack, peack, adbld}, exp);
    end
  endtask

  task automatic chk_err(string req, logic exp);
    n_checks++;
    if (perr !== exp) begin
      n_errors++;
      $display("FAIL %s protocol_error act=%b exp=%b", req, perr, exp);
    end
  endtask

  // inputs order: req_send, treq, rd_iq, adbld_out, ack_pkt
  task automatic drive(logic [4:0] v);
    @(negedge clk);
    {req_send, treq, rd_iq, adbld_out, ack_pkt} = v;
  endtask

  task automatic apply(logic [4:0] v);
    drive(v);
    repeat (3) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_ni = 1'b0;
    {req_send, treq, rd_iq, adbld_out, ack_pkt} = '0;
    repeat (2) @(negedge clk);
    chk_outs("R1 during reset", 3'b000);
    chk_err("R1 during reset", 1'b0);
    rst_ni = 1'b1;
    repeat (2) @(negedge clk);
    chk_outs("R1 after reset", 3'b000);
  endtask

  task automatic t_latency();
    do_reset();
    drive(5'b11100);
    repeat (2) @(posedge clk);
    @(negedge clk);
    chk_outs("R2 not after two edges", 3'b000);
    @(posedge clk);
    @(negedge clk);
    chk_outs("R2 after third edge", 3'b001);
  endtask

  task automatic t_main_loop();
    do_reset();
    apply(5'b11100); chk_outs("R3 s0->s1", 3'b001);
    apply(5'b01000); chk_outs("R9 s1 ignores others", 3'b001);
    apply(5'b11110); chk_outs("R3 s1->s2", 3'b011);
    apply(5'b11010); chk_outs("R3 s2->s3", 3'b100);
    apply(5'b10000); chk_outs("R9 s3 holds without rd/ack", 3'b100);
    apply(5'b10100); chk_outs("R4 s3->s4", 3'b101);
    apply(5'b10110); chk_outs("R5 s4->s5", 3'b111);
    apply(5'b10010); chk_outs("R5 s5->s6", 3'b000);
    apply(5'b11100); chk_outs("R6 s6->s1", 3'b001);
    apply(5'b11110); chk_outs("R3 s1->s2 again", 3'b011);
    apply(5'b11010); chk_outs("R3 s2->s3 again", 3'b100);
    apply(5'b10001); chk_outs("R4 s3->s8", 3'b110);
    apply(5'b10000); chk_outs("R7 s8->s9", 3'b000);
    apply(5'b11000); chk_outs("R8 s9->s10", 3'b100);
    apply(5'b10000); chk_outs("R8 s10->s9", 3'b000);
    apply(5'b00000); chk_outs("R8 s9->s0 no change", 3'b000);
    apply(5'b11100); chk_outs("R8 back in s0", 3'b001);
  endtask

  task automatic t_ack_path();
    do_reset();
    apply(5'b11100);
    apply(5'b11110);
    apply(5'b11010);
    apply(5'b10100);
    apply(5'b10110);
    apply(5'b10010); chk_outs("R5 reach s6", 3'b000);
    apply(5'b11001); chk_outs("R6 s6->s7", 3'b110);
    apply(5'b11000); chk_outs("R9 s7 needs treq low", 3'b110);
    apply(5'b10000); chk_outs("R7 s7->s9", 3'b000);
    apply(5'b01000); chk_outs("R8 treq wins over req_send low", 3'b100);
    apply(5'b00000); chk_outs("R8 s10->s9->s0", 3'b000);
    apply(5'b11100); chk_outs("R8 idle reached", 3'b001);
  endtask

  task automatic t_mutex();
    do_reset();
    apply(5'b11100);
    apply(5'b11110);
    apply(5'b11010); chk_outs("R10 at s3", 3'b100);
    chk_err("R10 clear before", 1'b0);
    apply(5'b10101);
    chk_err("R10 flag set", 1'b1);
    chk_outs("R10 outputs frozen", 3'b100);
    apply(5'b10100);
    chk_err("R10 sticky", 1'b1);
    chk_outs("R10 no arc after error", 3'b100);
    do_reset();
    chk_err("R1 reset clears flag", 1'b0);
  endtask

  initial begin
    {req_send, treq, rd_iq, adbld_out, ack_pkt} = '0;
    t_latency();
    t_main_loop();
    t_ack_path();
    t_mutex();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end

  initial begin
    #1000000;
    if (!done) begin
      n_checks++;
      n_errors++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
    end
  end

endmodule